// File: doc/BRIEF.md
# MCU Sleep Mode Controller

This block manages low-power states for a small microcontroller core. Software writes an 8-bit control register that holds a sleep-enable flag and a 3-bit mode code. When the core retires its sleep instruction, it raises a one-cycle strobe. If the enable flag is set and the mode is allowed, the controller leaves RUN and enters SLEEP. While asleep it drives five clock-enable outputs, one per clock domain: CPU, I/O, ADC, asynchronous timer and main oscillator.

An enabled interrupt, seen on `irq_i`, starts the wake-up sequence. Two modes stop the main oscillator: power-down and power-save. In those modes the controller first waits `START_CYC` cycles in WAKE_DELAY for the oscillator to start. In every mode it then holds the core for four cycles in HALT4. After that it returns to RUN and pulses `resume_o`, and the core continues at the instruction after the sleep instruction.

A reset request taken while the controller is not in RUN works differently. The controller returns to RUN on the next edge, pulses `reset_vec_o` and clears the control register. The core then starts from its reset vector instead of resuming. A normal wake-up never clears anything, so register and memory contents stay as they were.

States: RUN (0), SLEEP (1), WAKE_DELAY (2), HALT4 (3). The transitions are:
- RUN→SLEEP on a strobe with enable set and a legal mode.
- SLEEP→WAKE_DELAY on an interrupt in an oscillator-stopping mode.
- SLEEP→HALT4 on an interrupt in any other mode.
- WAKE_DELAY→HALT4 when the start-up count expires.
- HALT4→RUN after four cycles, with the resume pulse.
- SLEEP, WAKE_DELAY or HALT4→RUN on a reset request, with the reset-vector pulse.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: The control register is 8 bits wide and every bit is read/write. It resets to 0x00 and is read back on `reg_rdata_o`. Bit 5 is the sleep enable. Bits 4..2 are the mode code, with bit 4 as its most significant bit.
- R2: A strobe moves RUN to SLEEP only when bit 5 is 1 in that cycle. A strobe with bit 5 at 0 leaves the state at RUN with all clocks enabled.
- R3: Mode codes are: 000 idle, 001 ADC noise reduction, 010 power-down, 011 power-save, 110 standby, 111 extended standby. Codes 100 and 101 are reserved, and a strobe with a reserved code is ignored (the state stays RUN).
- R4: Codes 110 and 111 enter SLEEP only when `xtal_src_i` is 1. Otherwise the strobe is ignored.
- R5: Clock enables (1 = running) are written below in the order {osc, async, adc, io, cpu}. RUN gives 11111. In SLEEP: idle 11110, ADC noise reduction 11100, power-down 00000, power-save 01000, standby 10000, extended standby 11000.
- R6: An interrupt in SLEEP in power-down or power-save gives exactly `START_CYC` cycles of WAKE_DELAY and then exactly 4 cycles of HALT4. In any other mode the controller goes straight to 4 cycles of HALT4.
- R7: `resume_o` is high for exactly one cycle: the first RUN cycle after HALT4. An interrupt in RUN has no effect.
- R8: A reset request in SLEEP, WAKE_DELAY or HALT4 gives RUN on the next cycle. In that cycle `reset_vec_o` is high for one cycle, `resume_o` stays low and the register reads 0x00. A reset request in RUN is ignored.
- R9: `state_o` encodes RUN=0, SLEEP=1, WAKE_DELAY=2, HALT4=3. In WAKE_DELAY and HALT4 every clock except the CPU clock is enabled (11110).
- R10: A wake-up through an interrupt leaves the control register value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| sleep_strobe_i | input | 1 | One-cycle pulse: the core retired its sleep instruction |
| xtal_src_i | input | 1 | 1 when the clock source is an external crystal or resonator |
| irq_i | input | 1 | An enabled interrupt is pending |
| rst_req_i | input | 1 | A reset source fired |
| clk_en_cpu_o | output | 1 | CPU clock enable |
| clk_en_io_o | output | 1 | I/O clock enable |
| clk_en_adc_o | output | 1 | ADC clock enable |
| clk_en_async_o | output | 1 | Asynchronous timer clock enable |
| clk_en_osc_o | output | 1 | Main oscillator enable |
| state_o | output | 2 | Current state code |
| resume_o | output | 1 | One-cycle pulse: core resumes after the sleep instruction |
| reset_vec_o | output | 1 | One-cycle pulse: core restarts from its reset vector |

## Verification
The bench tries every mode code, including the two reserved codes and the standby codes with no external crystal. A decoder that accepted any of these would stop the core's clock when it should keep running. It measures WAKE_DELAY and HALT4 one cycle at a time, in modes that stop the oscillator and in modes that keep it running. An off-by-one counter, or a start-up delay applied in the wrong modes, changes those lengths. It raises a reset request during sleep, where a design that merged this exit with the normal one would pulse resume instead of the reset vector or would keep the old register value. It also reads the register back after a normal wake-up, so any unwanted clear shows up.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2,
        ST_HALT  = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic osc;
        logic async_tmr;
        logic adc;
        logic io;
        logic cpu;
    } clk_gate_t;

    localparam logic [2:0] MODE_IDLE  = 3'b000;
    localparam logic [2:0] MODE_ADCNR = 3'b001;
    localparam logic [2:0] MODE_PDOWN = 3'b010;
    localparam logic [2:0] MODE_PSAVE = 3'b011;
    localparam logic [2:0] MODE_RSV0  = 3'b100;
    localparam logic [2:0] MODE_RSV1  = 3'b101;
    localparam logic [2:0] MODE_STBY  = 3'b110;
    localparam logic [2:0] MODE_XSTBY = 3'b111;

    localparam int unsigned HALT_CYC = 4;

    localparam clk_gate_t GATE_ALL_ON = '{osc: 1'b1, async_tmr: 1'b1, adc: 1'b1, io: 1'b1, cpu: 1'b1};
    localparam clk_gate_t GATE_WAKING = '{osc: 1'b1, async_tmr: 1'b1, adc: 1'b1, io: 1'b1, cpu: 1'b0};

endpackage

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [7:0] wdata_i,
    input  logic       clear_i,
    output logic [7:0] rdata_o,
    output logic       se_o,
    output logic [2:0] mode_o
);
    localparam int SE_BIT   = 5;
    localparam int MODE_LSB = 2;

    logic [7:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (clear_i) ctrl_q <= '0;
        else if (we_i)    ctrl_q <= wdata_i;
    end

    assign rdata_o = ctrl_q;
    assign se_o    = ctrl_q[SE_BIT];
    assign mode_o  = ctrl_q[MODE_LSB +: 3];

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (ctrl_q == 8'h00)) else $error("clear did not zero register"); // R8
endmodule

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
    import pwr_sleep_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic       xtal_i,
    output logic       legal_o,
    output logic       needs_start_o
);
    always_comb begin
        legal_o       = 1'b1;
        needs_start_o = 1'b0;
        unique case (mode_i)
            MODE_IDLE, MODE_ADCNR:  ;
            MODE_PDOWN, MODE_PSAVE: needs_start_o = 1'b1;
            MODE_RSV0, MODE_RSV1:   legal_o = 1'b0;
            MODE_STBY, MODE_XSTBY:  legal_o = xtal_i;
            default:                legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_sleep_pkg::*;
#(
    parameter int unsigned START_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_i,
    input  logic       se_i,
    input  logic [2:0] mode_i,
    input  logic       legal_i,
    input  logic       needs_start_i,
    input  logic       irq_i,
    input  logic       rst_req_i,
    output pwr_state_e state_o,
    output logic [2:0] mode_q_o,
    output logic       resume_o,
    output logic       reset_vec_o,
    output logic       clear_o
);
    localparam int unsigned MAXC = (START_CYC > HALT_CYC) ? START_CYC : HALT_CYC;
    localparam int unsigned CW   = $clog2(MAXC) + 1;

    pwr_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [2:0] mode_q, mode_d;
    logic start_q, start_d;
    logic resume_q, resume_d, rvec_q, rvec_d;

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        mode_d   = mode_q;
        start_d  = start_q;
        resume_d = 1'b0;
        rvec_d   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (strobe_i && se_i && legal_i) begin
                    state_d = ST_SLEEP;
                    mode_d  = mode_i;
                    start_d = needs_start_i;
                end
            end
            ST_SLEEP: begin
                if (rst_req_i) begin
                    state_d = ST_RUN;
                    rvec_d  = 1'b1;
                end else if (irq_i) begin
                    if (start_q) begin
                        state_d = ST_WAKE;
                        cnt_d   = CW'(START_CYC - 1);
                    end else begin
                        state_d = ST_HALT;
                        cnt_d   = CW'(HALT_CYC - 1);
                    end
                end
            end
            ST_WAKE: begin
                if (rst_req_i) begin
                    state_d = ST_RUN;
                    rvec_d  = 1'b1;
                end else if (cnt_q == '0) begin
                    state_d = ST_HALT;
                    cnt_d   = CW'(HALT_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_HALT: begin
                if (rst_req_i) begin
                    state_d = ST_RUN;
                    rvec_d  = 1'b1;
                end else if (cnt_q == '0) begin
                    state_d  = ST_RUN;
                    resume_d = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            cnt_q    <= '0;
            mode_q   <= '0;
            start_q  <= 1'b0;
            resume_q <= 1'b0;
            rvec_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            mode_q   <= mode_d;
            start_q  <= start_d;
            resume_q <= resume_d;
            rvec_q   <= rvec_d;
        end
    end

    always_comb begin
        state_o     = state_q;
        mode_q_o    = mode_q;
        resume_o    = resume_q;
        reset_vec_o = rvec_q;
        clear_o     = rvec_d;
    end

    AST_ENTRY_NEEDS_SE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !se_i) |=> (state_q == ST_RUN)) else $error("sleep without enable"); // R2
    AST_NO_RESERVED_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP) |-> !(mode_q == MODE_RSV0 || mode_q == MODE_RSV1)) else $error("reserved mode slept"); // R3
    AST_WAKE_ONLY_OSC_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE) |-> (mode_q == MODE_PDOWN || mode_q == MODE_PSAVE)) else $error("delay in wrong mode"); // R6
    AST_HALT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> (cnt_q < CW'(HALT_CYC))) else $error("halt counter overrun"); // R6
    AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        resume_q |=> !resume_q) else $error("resume longer than one cycle"); // R7
    AST_RESUME_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_q) |-> ($past(state_q) == ST_HALT)) else $error("resume not after halt"); // R7
    AST_EXITS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(resume_q && rvec_q)) else $error("both exit pulses"); // R8
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
    import pwr_sleep_pkg::*;
(
    input  pwr_state_e state_i,
    input  logic [2:0] mode_i,
    output clk_gate_t  gate_o
);
    clk_gate_t sleep_mask;

    always_comb begin
        sleep_mask = '0;
        unique case (mode_i)
            MODE_IDLE:  sleep_mask = GATE_WAKING;
            MODE_ADCNR: sleep_mask = '{osc: 1'b1, async_tmr: 1'b1, adc: 1'b1, io: 1'b0, cpu: 1'b0};
            MODE_PSAVE: sleep_mask = '{osc: 1'b0, async_tmr: 1'b1, adc: 1'b0, io: 1'b0, cpu: 1'b0};
            MODE_STBY:  sleep_mask = '{osc: 1'b1, async_tmr: 1'b0, adc: 1'b0, io: 1'b0, cpu: 1'b0};
            MODE_XSTBY: sleep_mask = '{osc: 1'b1, async_tmr: 1'b1, adc: 1'b0, io: 1'b0, cpu: 1'b0};
            default:    sleep_mask = '0;
        endcase
    end

    always_comb begin
        unique case (state_i)
            ST_RUN:   gate_o = GATE_ALL_ON;
            ST_SLEEP: gate_o = sleep_mask;
            default:  gate_o = GATE_WAKING;
        endcase
    end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int unsigned START_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    input  logic       sleep_strobe_i,
    input  logic       xtal_src_i,
    input  logic       irq_i,
    input  logic       rst_req_i,
    output logic       clk_en_cpu_o,
    output logic       clk_en_io_o,
    output logic       clk_en_adc_o,
    output logic       clk_en_async_o,
    output logic       clk_en_osc_o,
    output logic [1:0] state_o,
    output logic       resume_o,
    output logic       reset_vec_o
);
    logic       se, legal, needs_start, clear;
    logic [2:0] mode_live, mode_held;
    pwr_state_e state;
    clk_gate_t  gate;

    pwr_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
        .clear_i(clear), .rdata_o(reg_rdata_o), .se_o(se), .mode_o(mode_live)
    );

    pwr_mode_decode u_dec (
        .mode_i(mode_live), .xtal_i(xtal_src_i),
        .legal_o(legal), .needs_start_o(needs_start)
    );

    pwr_seq_fsm #(.START_CYC(START_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .strobe_i(sleep_strobe_i), .se_i(se),
        .mode_i(mode_live), .legal_i(legal), .needs_start_i(needs_start),
        .irq_i(irq_i), .rst_req_i(rst_req_i), .state_o(state),
        .mode_q_o(mode_held), .resume_o(resume_o), .reset_vec_o(reset_vec_o),
        .clear_o(clear)
    );

    pwr_gate_ctrl u_gate (.state_i(state), .mode_i(mode_held), .gate_o(gate));

    assign state_o        = state;
    assign clk_en_cpu_o   = gate.cpu;
    assign clk_en_io_o    = gate.io;
    assign clk_en_adc_o   = gate.adc;
    assign clk_en_async_o = gate.async_tmr;
    assign clk_en_osc_o   = gate.osc;

    AST_CPU_OFF_WHEN_NOT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd0) |-> !clk_en_cpu_o) else $error("cpu clock on outside RUN"); // R9
    AST_RUN_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) |-> (clk_en_cpu_o && clk_en_io_o && clk_en_adc_o && clk_en_async_o && clk_en_osc_o))
        else $error("clock off in RUN"); // R5
    AST_WAKE_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> $stable(reg_rdata_o)) else $error("register changed on wake"); // R10
endmodule

// File: tb/pwr_sleep_ctrl_test.sv
module pwr_sleep_ctrl_test;
    localparam int START = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic we = 0, strobe = 0, xtal = 0, irq = 0, rreq = 0;
    logic [7:0] wdata = 0, rdata;
    logic en_cpu, en_io, en_adc, en_async, en_osc, resume, rvec;
    logic [1:0] state;
    logic [4:0] g;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    pwr_sleep_ctrl #(.START_CYC(START)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .sleep_strobe_i(strobe), .xtal_src_i(xtal), .irq_i(irq), .rst_req_i(rreq),
        .clk_en_cpu_o(en_cpu), .clk_en_io_o(en_io), .clk_en_adc_o(en_adc),
        .clk_en_async_o(en_async), .clk_en_osc_o(en_osc), .state_o(state),
        .resume_o(resume), .reset_vec_o(rvec)
    );

    assign g = {en_osc, en_async, en_adc, en_io, en_cpu};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(posedge clk); #1 we = 1; wdata = v;
        @(posedge clk); #1 we = 0;
    endtask

    task automatic pulse_strobe();
        @(posedge clk); #1 strobe = 1;
        @(posedge clk); #1 strobe = 0;
        @(negedge clk);
    endtask

    task automatic enter(input logic [2:0] m);
        write_reg({2'b00, 1'b1, m, 2'b00});
        pulse_strobe();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset reg", rdata, 8'h00);
        chk("R9 reset state", state, 0);
        chk("R5 reset gates", g, 5'b11111);
        chk("R7 reset resume", resume, 0);
        chk("R8 reset rvec", rvec, 0);
    endtask

    task automatic t_reg();
        write_reg(8'hA5); @(negedge clk);
        chk("R1 readback A5", rdata, 8'hA5);
        write_reg(8'h5A); @(negedge clk);
        chk("R1 readback 5A", rdata, 8'h5A);
        write_reg(8'h00);
    endtask

    task automatic t_no_se();
        write_reg(8'h08);
        pulse_strobe();
        chk("R2 no enable state", state, 0);
        chk("R2 no enable gates", g, 5'b11111);
        write_reg(8'h00);
    endtask

    task automatic t_reserved();
        xtal = 1;
        for (int m = 4; m <= 5; m++) begin
            enter(3'(m));
            chk("R3 reserved ignored", state, 0);
            chk("R3 reserved gates", g, 5'b11111);
        end
        write_reg(8'h00);
    endtask

    task automatic t_standby_noxtal();
        xtal = 0;
        for (int m = 6; m <= 7; m++) begin
            enter(3'(m));
            chk("R4 standby without crystal", state, 0);
        end
        write_reg(8'h00);
    endtask

    task automatic t_mode(input logic [2:0] m, input logic x, input logic [4:0] eg, input int ewake);
        int nw, nh;
        logic [4:0] gw;
        xtal = x;
        enter(m);
        chk("R2 entered sleep", state, 1);
        chk("R5 sleep gates", g, eg);
        @(posedge clk); #1 irq = 1;
        @(posedge clk); #1 irq = 0;
        @(negedge clk);
        gw = g;
        chk("R9 waking gates", gw, 5'b11110);
        nw = 0;
        for (int i = 0; i < 100 && state == 2'd2; i++) begin nw++; @(negedge clk); end
        nh = 0;
        for (int i = 0; i < 100 && state == 2'd3; i++) begin nh++; @(negedge clk); end
        chk("R6 wake delay length", nw, ewake);
        chk("R6 halt length", nh, 4);
        chk("R7 back in RUN", state, 0);
        chk("R7 resume high", resume, 1);
        chk("R8 no reset vector", rvec, 0);
        chk("R10 register kept", rdata, {2'b00, 1'b1, m, 2'b00});
        @(negedge clk);
        chk("R7 resume one cycle", resume, 0);
        write_reg(8'h00);
    endtask

    task automatic t_irq_run();
        @(posedge clk); #1 irq = 1;
        @(posedge clk); #1 irq = 0;
        @(negedge clk);
        chk("R7 irq in RUN state", state, 0);
        chk("R7 irq in RUN resume", resume, 0);
    endtask

    task automatic t_rst_sleep();
        xtal = 1;
        enter(3'b010);
        chk("R8 asleep before reset", state, 1);
        @(posedge clk); #1 rreq = 1;
        @(posedge clk); #1 rreq = 0;
        @(negedge clk);
        chk("R8 state RUN", state, 0);
        chk("R8 reset vector", rvec, 1);
        chk("R8 no resume", resume, 0);
        chk("R8 register cleared", rdata, 8'h00);
        @(negedge clk);
        chk("R8 reset vector one cycle", rvec, 0);
        write_reg(8'h24);
        @(posedge clk); #1 rreq = 1;
        @(posedge clk); #1 rreq = 0;
        @(negedge clk);
        chk("R8 RUN ignores reset req", rvec, 0);
        chk("R8 RUN keeps register", rdata, 8'h24);
        write_reg(8'h00);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_reg();
        t_no_se();
        t_reserved();
        t_standby_noxtal();
        t_mode(3'b000, 1'b0, 5'b11110, 0);
        t_mode(3'b001, 1'b0, 5'b11100, 0);
        t_mode(3'b010, 1'b0, 5'b00000, START);
        t_mode(3'b011, 1'b0, 5'b01000, START);
        t_mode(3'b110, 1'b1, 5'b10000, 0);
        t_mode(3'b111, 1'b1, 5'b11000, 0);
        t_irq_run();
        t_rst_sleep();
        finish_run();
    end
endmodule